// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

An up-counting timer with a single compare channel that drives one output pin. The counter advances by one on every clock and returns to zero after reaching its period limit (TOP). A compare register is checked against the count, and what the pin does on a compare match or at TOP depends on a 2-bit output action field together with the waveform mode. The mode is a small state machine loaded from the control write ports: NORMAL (free-running to all ones), CTC (clear-on-compare, TOP is the compare value), PWM_FULL (fast PWM with TOP all ones) and PWM_CMP (fast PWM with TOP equal to the compare value).

Software writes an 8-bit control word and a separate one-bit top-select flag, and writes the compare value. In the PWM states the compare value is double-buffered. A direction input enables the pin driver. When the waveform is not connected, the pin shows the port data input.

Mode state transitions: any cycle with a control write or a top-select write moves the state to the state decoded from the new fields. Wave field 00 or 01 goes to NORMAL, 10 goes to CTC, 11 with top-select 0 goes to PWM_FULL, and 11 with top-select 1 goes to PWM_CMP. If no write occurs, the state holds.

Top module: `tmr_wave`

## Requirements
- R1: Synchronous reset clears the counter, the compare value, the control word, the top-select flag and the internal output bit. Afterwards the count reads 0, the control readback reads 0x00 and the override flag is 0.
- R2: Control word layout: bits [7:6] are the output action (00 off, 01 toggle, 10 clear, 11 set), bits [1:0] are the wave field, and bits [5:2] always read back as 0. A write shows in the readback on the next cycle.
- R3: The count rises by 1 per clock and goes to 0 on the edge after TOP or all ones. TOP is all ones in NORMAL and PWM_FULL, and it is the active compare value in CTC and PWM_CMP.
- R4: In NORMAL and CTC, a match is the edge on which the count equals the active compare value. On that edge, action 01 toggles the output bit, 10 clears it and 11 sets it.
- R5: In PWM states, action 10 clears the output bit on a match and sets it at TOP, and action 11 sets it on a match and clears it at TOP.
- R6: In PWM_FULL, action 01 leaves the pin disconnected. In PWM_CMP, action 01 toggles the output bit on every match.
- R7: In a PWM state with action bit 7 set and the compare value equal to TOP, the match is ignored and only the TOP action applies.
- R8: In PWM states, a compare write goes to a buffer that becomes active on the wrap edge. In NORMAL and CTC, a compare write becomes active on the next edge.
- R9: The pin is overridden (override flag 1, pin shows the output bit) whenever the action is nonzero, except for action 01 in PWM_FULL. Otherwise the pin shows port data. The output bit keeps its value while disconnected.
- R10: The driver enable output follows the direction input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| ctl_we | input | 1 | control word write strobe |
| ctl_wdata | input | 8 | control word write data |
| tsel_we | input | 1 | top-select write strobe |
| tsel_wdata | input | 1 | top-select write data |
| cmp_we | input | 1 | compare write strobe |
| cmp_wdata | input | W | compare write data |
| port_d | input | 1 | port data shown when not overridden |
| dir_en | input | 1 | pin direction (driver enable) |
| ctl_rdata | output | 8 | control word readback |
| cnt_o | output | W | current count |
| pin_o | output | 1 | pin value |
| pin_oe | output | 1 | pin driver enable |
| ovr_o | output | 1 | waveform overrides the pin |

## Verification
The hardest case to reach is the PWM corner where a buffered compare value is loaded and equals TOP. This needs a compare write, then waiting for a wrap, all while in PWM_CMP. Directed segments write the compare value and then let whole periods run, so the buffered value loads and the TOP-only action shows on the pin. Random stimulus then mixes mode writes at arbitrary counts with compare writes, which covers buffer loads that collide with writes and mode changes in the middle of a period.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

    typedef enum logic [1:0] {
        MODE_NORM     = 2'd0,
        MODE_CTC      = 2'd1,
        MODE_PWM_FULL = 2'd2,
        MODE_PWM_CMP  = 2'd3
    } wmode_e;

    localparam logic [1:0] ACT_OFF = 2'b00;
    localparam logic [1:0] ACT_TGL = 2'b01;
    localparam logic [1:0] ACT_CLR = 2'b10;
    localparam logic [1:0] ACT_SET = 2'b11;

    function automatic wmode_e decode_mode(input logic tsel, input logic [1:0] wave);
        wmode_e m;
        unique case (wave)
            2'b10:   m = MODE_CTC;
            2'b11:   m = tsel ? MODE_PWM_CMP : MODE_PWM_FULL;
            default: m = MODE_NORM;
        endcase
        return m;
    endfunction

    function automatic logic is_pwm(input wmode_e m);
        return (m == MODE_PWM_FULL) || (m == MODE_PWM_CMP);
    endfunction

endpackage

// File: rtl/tmr_wave_ctl.sv
module tmr_wave_ctl
    import tmr_wave_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       tsel_we,
    input  logic       tsel_wdata,
    output logic [1:0] act,
    output wmode_e     mode,
    output logic [7:0] ctl_rdata
);
    localparam int RSV_W = 4;

    logic [1:0] act_q, act_n;
    logic [1:0] wave_q, wave_n;
    logic       tsel_q, tsel_n;
    wmode_e     state_q, state_n;
    logic       unused_rsv;

    assign unused_rsv = ^ctl_wdata[5:2];

    always_comb begin
        act_n   = ctl_we  ? ctl_wdata[7:6] : act_q;
        wave_n  = ctl_we  ? ctl_wdata[1:0] : wave_q;
        tsel_n  = tsel_we ? tsel_wdata     : tsel_q;
        state_n = state_q;
        if (ctl_we || tsel_we) begin
            state_n = decode_mode(tsel_n, wave_n);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= ACT_OFF;
            wave_q  <= 2'b00;
            tsel_q  <= 1'b0;
            state_q <= MODE_NORM;
        end else begin
            act_q   <= act_n;
            wave_q  <= wave_n;
            tsel_q  <= tsel_n;
            state_q <= state_n;
        end
    end

    always_comb begin
        act       = act_q;
        mode      = state_q;
        ctl_rdata = {act_q, {RSV_W{1'b0}}, wave_q};
    end

    // R2
    ctl_readback_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_rdata[7:6] == $past(ctl_wdata[7:6])) && (ctl_rdata[1:0] == $past(ctl_wdata[1:0])));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_we && !tsel_we) |=> $stable(mode));

endmodule

// File: rtl/tmr_wave_cnt.sv
module tmr_wave_cnt
    import tmr_wave_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  wmode_e       mode,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cnt,
    output logic         match,
    output logic         at_top
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;
    logic [W-1:0] top;
    logic         pwm;

    always_comb begin
        pwm = is_pwm(mode);
        unique case (mode)
            MODE_CTC, MODE_PWM_CMP: top = act_q;
            MODE_NORM, MODE_PWM_FULL: top = FULL;
        endcase
        at_top = (cnt_q == top) || (cnt_q == FULL);
        match  = (cnt_q == act_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            buf_q <= '0;
            act_q <= '0;
        end else begin
            cnt_q <= at_top ? '0 : cnt_q + 1'b1;
            if (cmp_we) begin
                buf_q <= cmp_wdata;
            end
            if (!pwm) begin
                if (cmp_we) begin
                    act_q <= cmp_wdata;
                end
            end else if (at_top) begin
                act_q <= cmp_we ? cmp_wdata : buf_q;
            end
        end
    end

    assign cnt = cnt_q;

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        at_top |=> (cnt == '0));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        !at_top |=> (cnt == $past(cnt) + 1'b1));

    // R8
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm && !at_top) |=> $stable(act_q));

    // R8
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwm && cmp_we) |=> (act_q == $past(cmp_wdata)));

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
    import tmr_wave_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wmode_e     mode,
    input  logic [1:0] act,
    input  logic       match,
    input  logic       at_top,
    input  logic       port_d,
    input  logic       dir_en,
    output logic       pin_o,
    output logic       pin_oe,
    output logic       ovr_o
);
    logic oc_q, oc_n;
    logic pwm;
    logic connected;

    always_comb begin
        pwm  = is_pwm(mode);
        oc_n = oc_q;
        unique case (mode)
            MODE_NORM, MODE_CTC: begin
                if (match) begin
                    unique case (act)
                        ACT_TGL: oc_n = !oc_q;
                        ACT_CLR: oc_n = 1'b0;
                        ACT_SET: oc_n = 1'b1;
                        ACT_OFF: oc_n = oc_q;
                    endcase
                end
            end
            MODE_PWM_FULL, MODE_PWM_CMP: begin
                unique case (act)
                    ACT_TGL: if (mode == MODE_PWM_CMP && match) oc_n = !oc_q;
                    ACT_CLR: begin
                        if (at_top)     oc_n = 1'b1;
                        else if (match) oc_n = 1'b0;
                    end
                    ACT_SET: begin
                        if (at_top)     oc_n = 1'b0;
                        else if (match) oc_n = 1'b1;
                    end
                    ACT_OFF: oc_n = oc_q;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) oc_q <= 1'b0;
        else     oc_q <= oc_n;
    end

    always_comb begin
        connected = (act != ACT_OFF) && !(mode == MODE_PWM_FULL && act == ACT_TGL);
        ovr_o     = connected;
        pin_o     = connected ? oc_q : port_d;
        pin_oe    = dir_en;
    end

    // R7
    top_wins_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm && act == ACT_CLR && at_top) |=> oc_q);

    // R5
    inv_top_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm && act == ACT_SET && at_top) |=> !oc_q);

    // R4
    match_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwm && act == ACT_SET && match) |=> oc_q);

    // R9
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_OFF) |=> $stable(oc_q));

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
    import tmr_wave_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_we,
    input  logic [7:0]   ctl_wdata,
    input  logic         tsel_we,
    input  logic         tsel_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         port_d,
    input  logic         dir_en,
    output logic [7:0]   ctl_rdata,
    output logic [W-1:0] cnt_o,
    output logic         pin_o,
    output logic         pin_oe,
    output logic         ovr_o
);
    logic [1:0] act;
    wmode_e     mode;
    logic       match;
    logic       at_top;

    tmr_wave_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .tsel_we    (tsel_we),
        .tsel_wdata (tsel_wdata),
        .act        (act),
        .mode       (mode),
        .ctl_rdata  (ctl_rdata)
    );

    tmr_wave_cnt #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .cnt       (cnt_o),
        .match     (match),
        .at_top    (at_top)
    );

    tmr_wave_out u_out (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .act    (act),
        .match  (match),
        .at_top (at_top),
        .port_d (port_d),
        .dir_en (dir_en),
        .pin_o  (pin_o),
        .pin_oe (pin_oe),
        .ovr_o  (ovr_o)
    );

    // R10
    oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_en) |-> pin_oe);

endmodule

// File: tb/tmr_wave_test.sv
module tmr_wave_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctl_we = 1'b0;
    logic [7:0]   ctl_wdata = '0;
    logic         tsel_we = 1'b0;
    logic         tsel_wdata = 1'b0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         port_d = 1'b0;
    logic         dir_en = 1'b0;
    logic [7:0]   ctl_rdata;
    logic [W-1:0] cnt_o;
    logic         pin_o, pin_oe, ovr_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_tag = "R4";

    logic [1:0]   m_act, m_wave;
    logic         m_tsel, m_oc;
    logic [W-1:0] m_cnt, m_buf, m_cmp;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_wave #(.W(W)) uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tsel_we(tsel_we), .tsel_wdata(tsel_wdata), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .port_d(port_d), .dir_en(dir_en),
        .ctl_rdata(ctl_rdata), .cnt_o(cnt_o), .pin_o(pin_o),
        .pin_oe(pin_oe), .ovr_o(ovr_o)
    );

    function automatic bit f_pwm();
        return m_wave == 2'b11;
    endfunction

    function automatic logic [W-1:0] f_top();
        if ((m_wave == 2'b10) || (f_pwm() && m_tsel)) return m_cmp;
        return {W{1'b1}};
    endfunction

    function automatic bit f_ovr();
        if (m_act == 2'b00) return 0;
        if (f_pwm() && !m_tsel && m_act == 2'b01) return 0;
        return 1;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_wave = 0; m_tsel = 0; m_oc = 0;
        m_cnt = 0; m_buf = 0; m_cmp = 0;
    endtask

    task automatic model_step();
        logic wrap, hit;
        logic [W-1:0] top;
        top  = f_top();
        wrap = (m_cnt == top) || (m_cnt == {W{1'b1}});
        hit  = (m_cnt == m_cmp);
        if (f_pwm()) begin
            if (m_act == 2'b01 && m_tsel && hit) m_oc = !m_oc;
            else if (m_act == 2'b10) begin
                if (wrap) m_oc = 1; else if (hit) m_oc = 0;
            end else if (m_act == 2'b11) begin
                if (wrap) m_oc = 0; else if (hit) m_oc = 1;
            end
            if (wrap) m_cmp = cmp_we ? cmp_wdata : m_buf;
        end else begin
            if (hit) begin
                if (m_act == 2'b01) m_oc = !m_oc;
                else if (m_act == 2'b10) m_oc = 0;
                else if (m_act == 2'b11) m_oc = 1;
            end
            if (cmp_we) m_cmp = cmp_wdata;
        end
        if (cmp_we) m_buf = cmp_wdata;
        m_cnt = wrap ? '0 : m_cnt + 1'b1;
        if (ctl_we) begin
            m_act  = ctl_wdata[7:6];
            m_wave = ctl_wdata[1:0];
        end
        if (tsel_we) m_tsel = tsel_wdata;
    endtask

    task automatic check_all();
        check("R3", cnt_o, m_cnt);
        check("R2", ctl_rdata, {m_act, 4'b0000, m_wave});
        check("R10", pin_oe, dir_en);
        check("R9", ovr_o, f_ovr());
        check(cur_tag, pin_o, f_ovr() ? m_oc : port_d);
    endtask

    task automatic cyc(input logic cw, input logic [7:0] cd, input logic tw, input logic td,
                       input logic mw, input logic [W-1:0] md, input logic pd, input logic de);
        ctl_we = cw; ctl_wdata = cd; tsel_we = tw; tsel_wdata = td;
        cmp_we = mw; cmp_wdata = md; port_d = pd; dir_en = de;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(input int n, input logic pd);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, pd, 1);
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        port_d = 1'b1;
        #1;
        // R1 reset state
        check("R1", cnt_o, 0);
        check("R1", ctl_rdata, 0);
        check("R1", ovr_o, 0);
        check("R1", pin_o, 1);
        rst = 1'b0;

        // R2 reserved bits read 0 after writing all ones there
        cur_tag = "R4";
        cyc(1, 8'b0011_1100, 0, 0, 0, 0, 0, 1);
        check("R2", ctl_rdata, 8'h00);

        // R4 CTC set on match, compare 5
        cyc(0, 0, 0, 0, 1, 8'd5, 0, 1);
        cyc(1, 8'b1100_0010, 0, 0, 0, 0, 0, 1);
        idle(20, 0);
        check("R4", pin_o, 1);
        // R4 toggle in normal mode
        cyc(1, 8'b0100_0000, 0, 0, 0, 0, 0, 1);
        idle(300, 0);

        // R9 disconnect holds output bit, port data shows
        cur_tag = "R9";
        cyc(1, 8'b1100_0000, 0, 0, 0, 0, 0, 1);
        idle(260, 0);
        cyc(1, 8'b0000_0000, 0, 0, 0, 0, 0, 1);
        idle(300, 0);
        check("R9", pin_o, 0);
        cyc(1, 8'b0100_0011, 1, 0, 0, 0, 1, 1);
        check("R6", ovr_o, 0);
        idle(20, 1);
        cyc(1, 8'b1100_0000, 0, 0, 0, 0, 0, 1);
        idle(3, 0);

        // R6 toggle in PWM_CMP
        cur_tag = "R6";
        cyc(0, 0, 0, 0, 1, 8'd9, 0, 1);
        cyc(1, 8'b0100_0011, 1, 1, 0, 0, 0, 1);
        idle(100, 0);

        // R5 non-inverting and inverting PWM with full top
        cur_tag = "R5";
        cyc(1, 8'b1000_0011, 1, 0, 1, 8'd40, 0, 1);
        idle(600, 0);
        cyc(1, 8'b1100_0011, 0, 0, 0, 0, 0, 1);
        idle(600, 0);

        // R8 buffered compare write in the middle of a period
        cur_tag = "R8";
        idle(100, 0);
        cyc(0, 0, 0, 0, 1, 8'd200, 0, 1);
        idle(700, 0);

        // R7 compare equal to TOP in PWM_CMP: output stays at TOP action
        cur_tag = "R7";
        cyc(1, 8'b1000_0011, 1, 1, 1, 8'd30, 0, 1);
        idle(200, 0);
        for (int i = 0; i < 40; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 1);
            check("R7", pin_o, 1);
        end
        cyc(1, 8'b1100_0011, 0, 0, 0, 0, 0, 1);
        idle(100, 0);
        check("R7", pin_o, 0);

        // random mix
        cur_tag = "R4";
        for (int i = 0; i < 30000; i++) begin
            logic cw, tw, mw;
            logic [7:0] cd;
            logic [W-1:0] md;
            cw = ($urandom % 64) == 0;
            tw = ($urandom % 64) == 0;
            mw = ($urandom % 16) == 0;
            cd = 8'($urandom);
            md = W'($urandom);
            cur_tag = (m_wave == 2'b11) ? "R5" : "R4";
            cyc(cw, cd, tw, 1'($urandom), mw, md, 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule